// File: doc/BRIEF.md
# Smart Card Contact Sequencer

This block switches the contacts of one smart card on and off in a fixed, timed order. An active-low session command starts activation. The card supply comes on first, then the I/O line, and finally the card reset is released. When the command returns high, the contacts go back down in the reverse order. Every step is timed in half-units of a base period T. T is 64 ticks of a slow oscillator, and each tick arrives as a one-cycle pulse from a prescaler.

A reset-request input plays two parts. During activation, if it was high when activation began and it falls after the I/O line is enabled but before the reset release, that falling edge starts the card clock. If it never falls in that window, the clock starts at the reset release. Once the card is active, the card reset output copies the reset-request input. A fault monitor can force the same power-down order at any time during activation or while active. A new session needs the command to go high and then low again.

Top module: `card_seq`

## Requirements
- R1: After reset all four contact outputs are low and the status output reads idle. The status encoding is 0 = idle, 1 = activating, 2 = active, 3 = deactivating.
- R2: The timing unit T is 64 `tick_i` pulses. The supply enable rises once 96 ticks have been counted after activation starts. With no tick, and with no abort, the supply and I/O enables do not change during activation.
- R3: The I/O enable rises once 256 ticks have been counted after activation starts. The card reset output is low in every state other than active.
- R4: The status becomes active once 448 ticks (7T) have been counted after activation starts. While active, `card_rst_o` equals `rst_req_i` in the same cycle.
- R5: The card clock can start on a falling edge of `rst_req_i` in the cycle after that edge is sampled. This holds only if `rst_req_i` was high when activation began and the edge falls at or after 4T. Otherwise the clock starts when the status becomes active. The clock is never on without the I/O enable.
- R6: A falling edge of `rst_req_i` before 4T does not start the clock. Edges of `rst_req_i` while active do not change the clock.
- R7: When the command returns high, the block enters deactivation in the next cycle and the card reset is low. The clock stops at 0.5T, the I/O enable falls at 1T and the supply enable falls at 1.5T. Only outputs that were on are kept on until those points. The block is idle at 2T, and the I/O enable is never on without the supply enable.
- R8: `fault_i` high while activating or active causes deactivation in the next cycle.
- R9: An activation starts only after `cmd_n_i` has been seen high since reset or since the previous activation began. A command held low through a fault or a reset does not reactivate the card.
- R10: The command returning high during activation aborts it into deactivation in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle oscillator tick from prescaler |
| cmd_n_i | input | 1 | Session command, low requests an active card |
| rst_req_i | input | 1 | Reset request from host |
| fault_i | input | 1 | Emergency power-down request |
| vcc_en_o | output | 1 | Card supply enable |
| io_en_o | output | 1 | Card I/O enable |
| clk_en_o | output | 1 | Card clock enable |
| card_rst_o | output | 1 | Card reset contact, high releases the card |
| state_o | output | 2 | Sequencer status |

## Verification
The hardest case to reach is the clock-start window. It needs `rst_req_i` high at the very start of activation and a falling edge somewhere between 4T and 7T. The stimulus sets the request high before dropping the command, then releases it at 5T in one session and at 2T in another, so both sides of the window boundary are covered. The bench also aborts a half-finished activation, leaving only the supply on, to check that deactivation keeps just that output until its drop point.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_ON    = 2'd2,
    ST_DEACT = 2'd3
  } seq_st_e;

  localparam int HALF_W = 4;

  // step points in half-units of T
  localparam logic [HALF_W-1:0] H_VCC_ON  = 4'd3;
  localparam logic [HALF_W-1:0] H_IO_ON   = 4'd8;
  localparam logic [HALF_W-1:0] H_RST_REL = 4'd14;
  localparam logic [HALF_W-1:0] H_CLK_OFF = 4'd1;
  localparam logic [HALF_W-1:0] H_IO_OFF  = 4'd2;
  localparam logic [HALF_W-1:0] H_VCC_OFF = 4'd3;
  localparam logic [HALF_W-1:0] H_DONE    = 4'd4;
endpackage

// File: rtl/card_seq_timer.sv
module card_seq_timer
  import card_seq_pkg::*;
#(
  parameter int TICKS_PER_T = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              tick_i,
  output logic [HALF_W-1:0] half_o
);
  localparam int HALF_TICKS = TICKS_PER_T / 2;
  localparam int SUB_W      = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(HALF_TICKS - 1);

  logic [SUB_W-1:0]  sub_q;
  logic [HALF_W-1:0] half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= '0;
      half_q <= '0;
    end else if (clear_i) begin
      sub_q  <= '0;
      half_q <= '0;
    end else if (run_i && tick_i) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        if (half_q != '1) half_q <= half_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign half_o = half_q;
endmodule

// File: rtl/card_seq_fsm.sv
module card_seq_fsm
  import card_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_n_i,
  input  logic              fault_i,
  input  logic              rst_req_i,
  input  logic [HALF_W-1:0] half_i,
  output seq_st_e           state_o,
  output logic              clear_o,
  output logic              run_o,
  output logic              enter_deact_o,
  output logic              clk_go_o
);
  seq_st_e state_q, state_d;
  logic    armed_q, rst_prev_q, rst_hi_q, clk_go_q;
  logic    start, abort, fall_in_window;

  assign start = (state_q == ST_IDLE) && armed_q && !cmd_n_i;
  assign abort = cmd_n_i || fault_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_ACT;
      ST_ACT: begin
        if (abort)                  state_d = ST_DEACT;
        else if (half_i == H_RST_REL) state_d = ST_ON;
      end
      ST_ON:    if (abort) state_d = ST_DEACT;
      ST_DEACT: if (half_i == H_DONE) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign fall_in_window = (state_q == ST_ACT) && (half_i >= H_IO_ON) &&
                          rst_hi_q && rst_prev_q && !rst_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      armed_q    <= 1'b0;
      rst_prev_q <= 1'b0;
      rst_hi_q   <= 1'b0;
      clk_go_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      rst_prev_q <= rst_req_i;
      if (cmd_n_i)    armed_q <= 1'b1;
      else if (start) armed_q <= 1'b0;
      if (start) begin
        rst_hi_q <= rst_req_i;
        clk_go_q <= 1'b0;
      end else if (fall_in_window) begin
        clk_go_q <= 1'b1;
      end
    end
  end

  assign state_o       = state_q;
  assign clear_o       = (state_d != state_q);
  assign run_o         = (state_q == ST_ACT) || (state_q == ST_DEACT);
  assign enter_deact_o = (state_d == ST_DEACT) && (state_q != ST_DEACT);
  assign clk_go_o      = clk_go_q;
endmodule

// File: rtl/card_seq_outdec.sv
module card_seq_outdec
  import card_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_st_e           state_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              clk_go_i,
  input  logic              enter_deact_i,
  input  logic              rst_req_i,
  output logic              vcc_en_o,
  output logic              io_en_o,
  output logic              clk_en_o,
  output logic              card_rst_o
);
  // {clk, io, vcc} as they were when power-down began
  logic [2:0] held_q;

  always_comb begin
    vcc_en_o   = 1'b0;
    io_en_o    = 1'b0;
    clk_en_o   = 1'b0;
    card_rst_o = 1'b0;
    unique case (state_i)
      ST_IDLE: ;
      ST_ACT: begin
        vcc_en_o = (half_i >= H_VCC_ON);
        io_en_o  = (half_i >= H_IO_ON);
        clk_en_o = clk_go_i;
      end
      ST_ON: begin
        vcc_en_o   = 1'b1;
        io_en_o    = 1'b1;
        clk_en_o   = 1'b1;
        card_rst_o = rst_req_i;
      end
      ST_DEACT: begin
        vcc_en_o = held_q[0] && (half_i < H_VCC_OFF);
        io_en_o  = held_q[1] && (half_i < H_IO_OFF);
        clk_en_o = held_q[2] && (half_i < H_CLK_OFF);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            held_q <= '0;
    else if (enter_deact_i) held_q <= {clk_en_o, io_en_o, vcc_en_o};
  end
endmodule

// File: rtl/card_seq.sv
module card_seq
  import card_seq_pkg::*;
#(
  parameter int TICKS_PER_T = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cmd_n_i,
  input  logic       rst_req_i,
  input  logic       fault_i,
  output logic       vcc_en_o,
  output logic       io_en_o,
  output logic       clk_en_o,
  output logic       card_rst_o,
  output logic [1:0] state_o
);
  seq_st_e           state;
  logic [HALF_W-1:0] half;
  logic              clear, run, enter_deact, clk_go;

  card_seq_timer #(.TICKS_PER_T(TICKS_PER_T)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .run_i   (run),
    .tick_i  (tick_i),
    .half_o  (half)
  );

  card_seq_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_n_i       (cmd_n_i),
    .fault_i       (fault_i),
    .rst_req_i     (rst_req_i),
    .half_i        (half),
    .state_o       (state),
    .clear_o       (clear),
    .run_o         (run),
    .enter_deact_o (enter_deact),
    .clk_go_o      (clk_go)
  );

  card_seq_outdec u_outdec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .half_i        (half),
    .clk_go_i      (clk_go),
    .enter_deact_i (enter_deact),
    .rst_req_i     (rst_req_i),
    .vcc_en_o      (vcc_en_o),
    .io_en_o       (io_en_o),
    .clk_en_o      (clk_en_o),
    .card_rst_o    (card_rst_o)
  );

  assign state_o = state;
endmodule

// File: rtl/card_seq_chk.sv
module card_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       cmd_n_i,
  input logic       rst_req_i,
  input logic       fault_i,
  input logic       vcc_en_o,
  input logic       io_en_o,
  input logic       clk_en_o,
  input logic       card_rst_o,
  input logic [1:0] state_o
);
  // R3
  rst_low_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd2 |-> !card_rst_o);

  // R4
  rst_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 |-> card_rst_o == rst_req_i);

  // R5
  clk_needs_io_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> io_en_o);

  // R7
  io_needs_vcc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_o |-> vcc_en_o);

  // R8
  fault_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 || state_o == 2'd2) && fault_i |=> state_o == 2'd3);

  // R10
  cmd_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 || state_o == 2'd2) && cmd_n_i |=> state_o == 2'd3);

  // R2
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd1 && !tick_i && !cmd_n_i && !fault_i
    |=> $stable(vcc_en_o) && $stable(io_en_o));
endmodule

bind card_seq card_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .cmd_n_i    (cmd_n_i),
  .rst_req_i  (rst_req_i),
  .fault_i    (fault_i),
  .vcc_en_o   (vcc_en_o),
  .io_en_o    (io_en_o),
  .clk_en_o   (clk_en_o),
  .card_rst_o (card_rst_o),
  .state_o    (state_o)
);

// File: tb/card_seq_bench.sv
`timescale 1ns/1ps
module card_seq_bench;
  localparam int HALF_TICKS = 32;
  localparam int HALF_CYC   = 2 * HALF_TICKS; // one tick every two cycles

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic cmd_n_i = 1'b0;
  logic rst_req_i = 1'b0;
  logic fault_i = 1'b0;
  logic vcc_en_o, io_en_o, clk_en_o, card_rst_o;
  logic [1:0] state_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  card_seq u_card_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cmd_n_i(cmd_n_i),
    .rst_req_i(rst_req_i), .fault_i(fault_i), .vcc_en_o(vcc_en_o),
    .io_en_o(io_en_o), .clk_en_o(clk_en_o), .card_rst_o(card_rst_o),
    .state_o(state_o)
  );

  always #4 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (!rst_ni) tick_i <= 1'b0;
    else         tick_i <= ~tick_i;
  end

  // behavioural reference
  int m_st = 0, m_el = 0;
  bit m_armed = 0, m_prev = 0, m_hi = 0, m_go = 0;
  bit [2:0] m_held = 0;
  bit e_vcc, e_io, e_clk, e_rst;

  task automatic model_out();
    int h;
    h = m_el / HALF_TICKS;
    e_vcc = 0; e_io = 0; e_clk = 0; e_rst = 0;
    case (m_st)
      1: begin e_vcc = (h >= 3); e_io = (h >= 8); e_clk = m_go; end
      2: begin e_vcc = 1; e_io = 1; e_clk = 1; e_rst = rst_req_i; end
      3: begin e_vcc = m_held[0] && h < 3; e_io = m_held[1] && h < 2; e_clk = m_held[2] && h < 1; end
      default: ;
    endcase
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_el = 0; m_armed = 0; m_prev = 0; m_hi = 0; m_go = 0; m_held = 0;
    end else begin
      int h, nxt;
      bit st;
      h = m_el / HALF_TICKS;
      model_out();
      nxt = m_st; st = 0;
      case (m_st)
        0: if (m_armed && !cmd_n_i) begin nxt = 1; st = 1; end
        1: if (cmd_n_i || fault_i) nxt = 3; else if (h == 14) nxt = 2;
        2: if (cmd_n_i || fault_i) nxt = 3;
        3: if (h == 4) nxt = 0;
        default: nxt = 0;
      endcase
      if (nxt == 3 && m_st != 3) m_held = {e_clk, e_io, e_vcc};
      if (st) begin m_go = 0; m_hi = rst_req_i; end
      else if (m_st == 1 && h >= 8 && m_hi && m_prev && !rst_req_i) m_go = 1;
      if (cmd_n_i) m_armed = 1; else if (st) m_armed = 0;
      m_prev = rst_req_i;
      if (nxt != m_st) m_el = 0;
      else if (tick_i && (m_st == 1 || m_st == 3)) m_el++;
      m_st = nxt;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(negedge clk_i) begin
    #3;
    if (rst_ni && !done) begin
      cycles++;
      model_out();
      chk(state_o == 2'(m_st), "R1 state", state_o, m_st);
      chk(vcc_en_o == e_vcc, "R2 vcc_en", vcc_en_o, e_vcc);
      chk(io_en_o == e_io, "R3 io_en", io_en_o, e_io);
      chk(clk_en_o == e_clk, "R5 clk_en", clk_en_o, e_clk);
      chk(card_rst_o == e_rst, "R4 card_rst", card_rst_o, e_rst);
      if (cycles > 150000) begin
        chk(0, "watchdog", cycles, 150000);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic halves(input int n);
    step(n * HALF_CYC);
  endtask

  initial begin
    step(5);
    #1;
    // R1 reset state
    chk({vcc_en_o, io_en_o, clk_en_o, card_rst_o} == 4'b0, "R1 outputs", {vcc_en_o, io_en_o, clk_en_o, card_rst_o}, 0);
    chk(state_o == 2'd0, "R1 idle", state_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    step(20); #1;
    // R9 command low since reset: no session
    chk(state_o == 2'd0, "R9 not armed", state_o, 0);

    // session 1: clock started by request fall in window
    @(negedge clk_i) cmd_n_i = 1'b1;
    step(2); rst_req_i = 1'b1; cmd_n_i = 1'b0;
    halves(10); #1;
    chk(io_en_o == 1'b1, "R3 io at 5T", io_en_o, 1);
    chk(clk_en_o == 1'b0, "R5 clk before fall", clk_en_o, 0);
    @(negedge clk_i) rst_req_i = 1'b0;
    step(2); #1;
    chk(clk_en_o == 1'b1, "R5 clk on fall", clk_en_o, 1);
    halves(5); #1;
    chk(state_o == 2'd2, "R4 active", state_o, 2);
    @(negedge clk_i) rst_req_i = 1'b1;
    #1 chk(card_rst_o == 1'b1, "R4 copy high", card_rst_o, 1);
    @(negedge clk_i) rst_req_i = 1'b0;
    #1 chk(card_rst_o == 1'b0 && clk_en_o == 1'b1, "R6 clk unaffected", clk_en_o, 1);
    @(negedge clk_i) cmd_n_i = 1'b1;
    step(1); #1;
    chk(state_o == 2'd3 && card_rst_o == 1'b0, "R7 deact entry", state_o, 3);
    halves(5); #1;
    chk(state_o == 2'd0 && vcc_en_o == 1'b0, "R7 back idle", state_o, 0);

    // session 2: request low throughout, clock at release; fault
    @(negedge clk_i) cmd_n_i = 1'b0;
    halves(13); #1;
    chk(clk_en_o == 1'b0, "R5 no clk before 7T", clk_en_o, 0);
    halves(2); #1;
    chk(clk_en_o == 1'b1 && state_o == 2'd2, "R5 clk at release", clk_en_o, 1);
    @(negedge clk_i) fault_i = 1'b1;
    @(negedge clk_i) fault_i = 1'b0;
    #1 chk(state_o == 2'd3, "R8 fault active", state_o, 3);
    halves(5); step(10); #1;
    chk(state_o == 2'd0, "R9 no rearm", state_o, 0);

    // session 3: early fall before window
    @(negedge clk_i) cmd_n_i = 1'b1;
    step(2); rst_req_i = 1'b1; cmd_n_i = 1'b0;
    halves(4); rst_req_i = 1'b0;
    halves(8); #1;
    chk(clk_en_o == 1'b0, "R6 early fall ignored", clk_en_o, 0);
    halves(3); #1;
    chk(clk_en_o == 1'b1, "R5 clk at release", clk_en_o, 1);
    @(negedge clk_i) cmd_n_i = 1'b1;
    halves(5);

    // session 4: abort during activation
    @(negedge clk_i) cmd_n_i = 1'b0;
    halves(4);
    cmd_n_i = 1'b1;
    step(1); #1;
    chk(state_o == 2'd3, "R10 abort", state_o, 3);
    chk(vcc_en_o == 1'b1 && io_en_o == 1'b0, "R7 held supply only", io_en_o, 0);
    halves(5); #1;
    chk(vcc_en_o == 1'b0 && state_o == 2'd0, "R7 supply dropped", vcc_en_o, 0);

    // session 5: fault during activation
    @(negedge clk_i) cmd_n_i = 1'b0;
    halves(10);
    fault_i = 1'b1;
    @(negedge clk_i) fault_i = 1'b0;
    #1 chk(state_o == 2'd3, "R8 fault activating", state_o, 3);
    @(negedge clk_i) cmd_n_i = 1'b1;
    halves(5); #1;
    chk(state_o == 2'd0, "R7 idle after fault", state_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule